// File: doc/BRIEF.md
# Background Tile Row Fetch Sequencer

This block fetches one 8-pixel row of a background or window tile at a time and hands it to a background pixel queue during active line output. It reads a tile number from one of two 32x32 tile maps, then the low and high bit-plane bytes of the selected row of that tile, from an 8-bit video memory read port. It then offers the row to the queue every dot until the queue is empty.

The map address is built from the current line, the scroll offsets and an internal column counter. In window mode it is built from the window line counter and a window-relative column. The tile data address uses either unsigned tile numbering, or signed numbering that folds tiles 0 to 127 into a second bank. While the finished row waits in the push step and the queue still holds pixels, the block grants the shared fetch path to a sprite fetch. If that fetch takes the path, the row is dropped and fetched again. A window trigger flushes the queue and restarts the sequence in window mode.

Top module: `tile_row_sequencer`

## Requirements
- R1: The steps follow the order tile number, low plane, high plane, push, and each fetch step lasts 2 dots. Counting the first dot of the tile number step as dot 0, `vram_rd` is high on dots 1, 3 and 5 only, and the push step starts on dot 6.
- R2: In background mode the tile number read uses address {5'b10011, `bg_map_hi`, s[7:3], x[7:3]}. Here s = (`line` + `scy`) mod 256, and x = (column + `scx`) mod 256.
- R3: In window mode the tile number read uses address {5'b10011, `win_map_hi`, `win_line`[7:3], column[7:3]}. The tile row is `win_line` mod 8.
- R4: Each bit-plane read uses address {3'b100, b, t[7:0], r[2:0], p}. Here t is the tile number read on dot 1, b = NOT(`tile_unsigned` OR t[7]), and p is 0 for the low plane and 1 for the high plane. The bytes read appear on `row_lo` and `row_hi` during the push step.
- R5: In background mode the tile row r is (`line` + `scy`) mod 8. When `vflip` is high, all three bits of r are inverted.
- R6: In the push step, `push` is high on every dot on which `q_empty` is high. On a push the column advances by 8 and the next dot starts a new tile number step. While `q_empty` is low the block stays in the push step.
- R7: `obj_grant` is high only in the push step while `q_empty` is low. If `obj_take` is high on such a dot, the fetched row is dropped and the next dot restarts the tile number step at the same column.
- R8: A dot with `win_trig` high drives `q_flush` high and suppresses `push` and `obj_grant`. The next dot starts a tile number step in window mode with the column at 0.
- R9: While `run` is low there are no reads, pushes or grants, and the block returns to background mode with the column at 0 and the tile number step next.
- R10: After reset `vram_rd`, `push`, `obj_grant` and `q_flush` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High during active pixel output of a line |
| line | input | 8 | Current line number |
| scy | input | 8 | Vertical scroll |
| scx | input | 8 | Horizontal scroll |
| win_line | input | 8 | Internal window line counter |
| bg_map_hi | input | 1 | Selects the upper tile map for background |
| win_map_hi | input | 1 | Selects the upper tile map for window |
| tile_unsigned | input | 1 | Unsigned tile numbering when high |
| vflip | input | 1 | Inverts the tile row |
| win_trig | input | 1 | Window start trigger |
| q_empty | input | 1 | Background queue is empty |
| obj_take | input | 1 | Sprite fetch takes the fetch path |
| vram_data | input | 8 | Read data, valid in the dot of the read |
| vram_rd | output | 1 | Read strobe |
| vram_addr | output | 16 | Read address |
| push | output | 1 | Row accepted by the background queue |
| row_lo | output | 8 | Low plane byte of the row |
| row_hi | output | 8 | High plane byte of the row |
| obj_grant | output | 1 | Sprite fetch may take over |
| q_flush | output | 1 | Clear the background queue |

## Verification
The assertions check on every dot the relations that hold at the ports. Reads never fall on two consecutive dots, and every read address lies in the 0x8000 to 0x9FFF range. A push is never followed by a read or another push. A grant implies a non-empty queue, and a pending grant persists until the queue empties, a trigger arrives or `run` drops. A take or a window trigger is followed by a dot with no read and no push. The exact address bits must be checked by the bench scenarios: map indices with scroll wrap, window map and row, signed tile banking, vertical flip, and refetching the same column after a takeover. The same holds for the column step after a push and for the return to background mode when `run` drops.

// File: rtl/tile_row_sequencer.sv
module tile_row_sequencer #(
  parameter logic [4:0] MAP_BASE  = 5'b10011,
  parameter logic [2:0] DATA_BASE = 3'b100,
  parameter int         ROW_W     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic [7:0]  line,
  input  logic [7:0]  scy,
  input  logic [7:0]  scx,
  input  logic [7:0]  win_line,
  input  logic        bg_map_hi,
  input  logic        win_map_hi,
  input  logic        tile_unsigned,
  input  logic        vflip,
  input  logic        win_trig,
  input  logic        q_empty,
  input  logic        obj_take,
  input  logic [7:0]  vram_data,
  output logic        vram_rd,
  output logic [15:0] vram_addr,
  output logic        push,
  output logic [7:0]  row_lo,
  output logic [7:0]  row_hi,
  output logic        obj_grant,
  output logic        q_flush
);
  localparam logic [7:0] COL_STEP = 8'(ROW_W);

  typedef enum logic [2:0] {S_ID0, S_ID1, S_LO0, S_LO1, S_HI0, S_HI1, S_PUSH} step_t;

  step_t      st;
  logic [7:0] col, tid;
  logic       win;

  wire [7:0]  ysum = line + scy;
  wire [7:0]  xsum = col + scx;
  wire [2:0]  row  = (win ? win_line[2:0] : ysum[2:0]) ^ {3{vflip}};

  wire [15:0] map_a = win ? {MAP_BASE, win_map_hi, win_line[7:3], col[7:3]}
                          : {MAP_BASE, bg_map_hi, ysum[7:3], xsum[7:3]};
  wire [15:0] dat_a = {DATA_BASE, ~(tile_unsigned | tid[7]), tid, row, st == S_HI1};

  wire in_push = run && st == S_PUSH && !win_trig;

  assign vram_rd   = run && (st == S_ID1 || st == S_LO1 || st == S_HI1);
  assign vram_addr = (st == S_ID1) ? map_a : dat_a;
  assign push      = in_push && q_empty;
  assign obj_grant = in_push && !q_empty;
  assign q_flush   = run && win_trig;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      st  <= S_ID0;
      col <= '0;
      win <= 1'b0;
      if (!rst_n) begin
        tid    <= '0;
        row_lo <= '0;
        row_hi <= '0;
      end
    end else if (win_trig) begin
      st  <= S_ID0;
      col <= '0;
      win <= 1'b1;
    end else begin
      case (st)
        S_ID1: tid    <= vram_data;
        S_LO1: row_lo <= vram_data;
        S_HI1: row_hi <= vram_data;
        default: ;
      endcase
      if (st == S_PUSH) begin
        if (q_empty) begin
          col <= col + COL_STEP;
          st  <= S_ID0;
        end else if (obj_take) begin
          st <= S_ID0;
        end
      end else begin
        st <= step_t'(st + 3'd1);
      end
    end
  end
endmodule

// File: rtl/tile_row_sequencer_chk.sv
module tile_row_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        win_trig,
  input logic        q_empty,
  input logic        obj_take,
  input logic        vram_rd,
  input logic [15:0] vram_addr,
  input logic        push,
  input logic        obj_grant
);
  p_read_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd |=> !vram_rd);

  p_addr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd |-> vram_addr[15:13] == 3'b100);

  p_push_then_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push && !vram_rd);

  p_push_needs_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> q_empty);

  p_wait_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (obj_grant && !obj_take) |=> (!run || win_trig || obj_grant || push));

  p_grant_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    obj_grant |-> !q_empty && !push);

  p_take_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (obj_grant && obj_take) |=> !vram_rd && !push);

  p_trig_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && win_trig) |=> !vram_rd && !push);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !vram_rd && !push && !obj_grant);
endmodule

bind tile_row_sequencer tile_row_sequencer_chk i_chk (.*);

// File: tb/test_tile_row_sequencer.sv
`timescale 1ns/1ps
module test_tile_row_sequencer;
  logic clk = 0, rst_n = 0, run = 0;
  logic [7:0] line = 0, scy = 0, scx = 0, win_line = 0;
  logic bg_map_hi = 0, win_map_hi = 0, tile_unsigned = 0, vflip = 0;
  logic win_trig = 0, q_empty = 1, obj_take = 0;
  logic [7:0] vram_data, row_lo, row_hi, map_tid = 0;
  logic vram_rd, push, obj_grant, q_flush;
  logic [15:0] vram_addr;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] hash(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_comb vram_data = (vram_addr >= 16'h9800) ? map_tid : hash(vram_addr);

  tile_row_sequencer i_tile_row_sequencer (.*);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dat(input logic [7:0] t, input logic [2:0] r,
                                      input logic p);
    return {3'b100, ~(tile_unsigned | t[7]), t, r, p};
  endfunction

  // Called in the first dot of a tile number step; returns in the push step.
  task automatic fetch(input logic [15:0] exp_map, input logic [2:0] r, input string req);
    logic [15:0] a;
    tick;
    chk(vram_rd === 1 && vram_addr === exp_map, req, "map read addr", vram_addr, exp_map);
    tick;
    chk(vram_rd === 0, "R1", "no read on dot 2", vram_rd, 0);
    tick;
    a = dat(map_tid, r, 0);
    chk(vram_rd === 1 && vram_addr === a, req, "low plane addr", vram_addr, a);
    tick; tick;
    a = dat(map_tid, r, 1);
    chk(vram_rd === 1 && vram_addr === a, req, "high plane addr", vram_addr, a);
    tick;
    chk(row_lo === hash(dat(map_tid, r, 0)) && row_hi === hash(a), "R4", "row bytes",
        {row_hi, row_lo}, {hash(a), hash(dat(map_tid, r, 0))});
  endtask

  task automatic t_reset;
    chk(!vram_rd && !push && !obj_grant && !q_flush, "R10", "outputs after reset",
        {vram_rd, push, obj_grant, q_flush}, 0);
  endtask

  task automatic t_background;
    line = 8'h13; scy = 8'h26; scx = 8'hFC; map_tid = 8'h05; q_empty = 1;
    run = 1;
    fetch({5'b10011, 1'b0, 5'd7, 5'd31}, 3'd1, "R2");
    chk(push === 1 && obj_grant === 0, "R6", "push on empty queue", push, 1);
    tick;
    chk(vram_rd === 0 && push === 0, "R1", "push leads to tile number step", vram_rd, 0);
  endtask

  task automatic t_wrap_flip_wait;
    bg_map_hi = 1; tile_unsigned = 1; vflip = 1; map_tid = 8'h85; q_empty = 0;
    fetch({5'b10011, 1'b1, 5'd7, 5'd0}, 3'd6, "R5");
    chk(obj_grant === 1 && push === 0, "R7", "grant while queue busy", obj_grant, 1);
    tick;
    chk(obj_grant === 1 && push === 0 && vram_rd === 0, "R6", "still waiting", push, 0);
    q_empty = 1; #1;
    chk(push === 1 && obj_grant === 0, "R6", "push once empty", push, 1);
    tick;
  endtask

  task automatic t_signed_take;
    bg_map_hi = 0; tile_unsigned = 0; vflip = 0; map_tid = 8'h80; q_empty = 0;
    fetch({5'b10011, 1'b0, 5'd7, 5'd1}, 3'd1, "R4");
    obj_take = 1; #1;
    chk(obj_grant === 1, "R7", "grant before take", obj_grant, 1);
    tick;
    obj_take = 0; map_tid = 8'h22; q_empty = 1;
    chk(vram_rd === 0 && push === 0, "R7", "row dropped after take", push, 0);
    fetch({5'b10011, 1'b0, 5'd7, 5'd1}, 3'd1, "R7");
    chk(push === 1, "R7", "push after refetch", push, 1);
    tick;
  endtask

  task automatic t_window;
    win_map_hi = 1; win_line = 8'h2B; map_tid = 8'h10;
    tick; tick;
    win_trig = 1; #1;
    chk(q_flush === 1 && push === 0 && vram_rd === 0, "R8", "flush on trigger", q_flush, 1);
    tick;
    win_trig = 0;
    fetch({5'b10011, 1'b1, 5'd5, 5'd0}, 3'd3, "R3");
    chk(push === 1, "R8", "window row pushed", push, 1);
    tick;
    fetch({5'b10011, 1'b1, 5'd5, 5'd1}, 3'd3, "R3");
    tick;
  endtask

  task automatic t_idle;
    run = 0;
    for (int i = 0; i < 4; i++) begin
      tick;
      chk(!vram_rd && !push && !obj_grant, "R9", "idle quiet", vram_rd, 0);
    end
    run = 1; map_tid = 8'h41;
    fetch({5'b10011, 1'b0, 5'd7, 5'd31}, 3'd1, "R9");
    tick;
  endtask

  initial begin
    tick; tick;
    rst_n = 1;
    tick;
    t_reset;
    t_background;
    t_wrap_flip_wait;
    t_signed_take;
    t_window;
    t_idle;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule